// File: doc/BRIEF.md
# Interrupt Flag and Mask Controller

This block collects single-cycle event pulses from five peripheral sources into one 8-bit control register. The sources are two timers, a time-of-day alarm, a serial shift register and an external flag input. Each pulse sets a sticky flag. A separate enable mask chooses which flags may drive the active-high interrupt request.

The CPU reaches the block through a single register location. A read returns every latched flag, whether or not it is enabled, together with a summary bit that shows whether any enabled flag is pending. The read also clears all flags at the clock edge that ends the read cycle. A write at the same location edits the mask. Bit 7 of the write data picks the edit: when it is 1, each 1 in the source bits sets the matching mask bit; when it is 0, each 1 clears the matching mask bit. Source bits that are 0 leave their mask bits as they are.

The read data is combinational from the stored state. The interrupt request is a register. It is loaded from the next-cycle flag and mask values, so it always matches the summary bit that a read would return.

Top module: `irq_ctl_top`

## Requirements
- R1: A pulse on `src_evt[i]` sets flag bit i. The bit order is: bit0 timer A, bit1 timer B, bit2 alarm, bit3 shift register, bit4 external flag pin. Read-data bits 6:5 always read 0.
- R2: `rd_data[4:0]` shows every latched flag, whether or not its mask bit is set.
- R3: `rd_data[7]` is 1 exactly when at least one latched flag has its mask bit set.
- R4: A cycle with `rd_en` high clears all flags at the closing clock edge, so a read in the next cycle returns 0x00 if no new event has arrived.
- R5: A write with `wr_data[7]`=1 sets each mask bit whose position in `wr_data[4:0]` holds a 1. A write of 0x81 therefore enables timer A.
- R6: A write with `wr_data[7]`=0 clears each mask bit whose position in `wr_data[4:0]` holds a 1. Zero bits leave mask bits unchanged, and `wr_data[6:5]` are ignored.
- R7: `irq` is high in the cycle after the clock edge at which some flag is latched with its mask bit set. This includes setting the mask bit of a flag that is already pending. A source whose mask bit is clear never raises `irq`.
- R8: `irq` stays high until a read clears the enabled flags. An event that arrives in the same cycle as a read is kept as a flag.
- R9: A synchronous reset clears all flags and all mask bits and drives `irq` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe; clears flags at the closing edge |
| wr_en | input | 1 | Write strobe; edits the mask |
| wr_data | input | 8 | Write data: bit 7 selects set or clear, bits 4:0 select sources |
| rd_data | output | 8 | Read data: bit 7 summary, bits 4:0 flags |
| src_evt | input | 5 | One-cycle event pulses, one per source |
| irq | output | 1 | Active-high interrupt request |

## Verification
The bench builds the block with its default parameters: five sources and an 8-bit register. With these values the two unused bits 6:5 exist, so the bench can confirm that they read as zero and that write data in those positions has no effect. The five-bit source vector is small enough for the vector table to fire every source at once. The table also covers an event arriving in the same cycle as a read, a read and a write in the same cycle, and enabling a flag that is already pending. These cases are where the next-state ordering of flags, mask and request matters.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    localparam int DEF_NUM_SRC = 5;
    localparam int DEF_DATA_W  = 8;

    // Source bit positions; software decodes these positions.
    typedef enum int {
        SRC_TIMER_A = 0,
        SRC_TIMER_B = 1,
        SRC_ALARM   = 2,
        SRC_SHIFT   = 3,
        SRC_EXT_PIN = 4
    } src_idx_e;

    // Mask edit mode carried in the top data bit of a write.
    typedef enum logic {
        MASK_CLEAR = 1'b0,
        MASK_SET   = 1'b1
    } mask_mode_e;

    // Per-bit mask edit: a selected bit takes the mode value, others hold.
    function automatic logic mask_bit_next(input logic cur, input logic sel,
                                           input logic stb, input mask_mode_e mode);
        logic nxt;
        nxt = cur;
        if (stb && sel) begin
            nxt = (mode == MASK_SET);
        end
        return nxt;
    endfunction

    // Per-bit flag update: a new event wins over a clear.
    function automatic logic flag_bit_next(input logic cur, input logic clr,
                                           input logic evt);
        return (cur & ~clr) | evt;
    endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_ctl_pkg::*;
#(
    parameter int NUM_SRC = DEF_NUM_SRC
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_all,
    input  logic [NUM_SRC-1:0] src_evt,
    output logic [NUM_SRC-1:0] flags_d,
    output logic [NUM_SRC-1:0] flags_q
);

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_flag
        assign flags_d[gi] = flag_bit_next(flags_q[gi], clr_all, src_evt[gi]);

        always_ff @(posedge clk) begin
            if (rst) begin
                flags_q[gi] <= 1'b0;
            end else begin
                flags_q[gi] <= flags_d[gi];
            end
        end
    end

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
    import irq_ctl_pkg::*;
#(
    parameter int NUM_SRC = DEF_NUM_SRC
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_stb,
    input  mask_mode_e         mode,
    input  logic [NUM_SRC-1:0] sel,
    output logic [NUM_SRC-1:0] mask_d,
    output logic [NUM_SRC-1:0] mask_q
);

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_mask
        assign mask_d[gi] = mask_bit_next(mask_q[gi], sel[gi], wr_stb, mode);

        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q[gi] <= 1'b0;
            end else begin
                mask_q[gi] <= mask_d[gi];
            end
        end
    end

endmodule

// File: rtl/irq_summary.sv
module irq_summary
    import irq_ctl_pkg::*;
#(
    parameter int NUM_SRC = DEF_NUM_SRC
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] flags_q,
    input  logic [NUM_SRC-1:0] mask_q,
    input  logic [NUM_SRC-1:0] flags_d,
    input  logic [NUM_SRC-1:0] mask_d,
    output logic               pend_now,
    output logic               irq_q
);

    logic pend_next;

    // Present-state summary feeds the read data.
    assign pend_now  = |(flags_q & mask_q);
    // Next-state summary feeds the request register so both agree.
    assign pend_next = |(flags_d & mask_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= pend_next;
        end
    end

endmodule

// File: rtl/irq_ctl_top.sv
module irq_ctl_top
    import irq_ctl_pkg::*;
#(
    parameter int NUM_SRC = DEF_NUM_SRC,
    parameter int DATA_W  = DEF_DATA_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data,
    input  logic [NUM_SRC-1:0] src_evt,
    output logic               irq
);

    localparam int SUM_BIT = DATA_W - 1;
    localparam int GAP_W   = SUM_BIT - NUM_SRC;

    logic [NUM_SRC-1:0] flags_d;
    logic [NUM_SRC-1:0] flags_q;
    logic [NUM_SRC-1:0] mask_d;
    logic [NUM_SRC-1:0] mask_q;
    logic               pend_now;
    mask_mode_e         wr_mode;

    assign wr_mode = mask_mode_e'(wr_data[SUM_BIT]);

    irq_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .clr_all (rd_en),
        .src_evt (src_evt),
        .flags_d (flags_d),
        .flags_q (flags_q)
    );

    irq_mask_bank #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk    (clk),
        .rst    (rst),
        .wr_stb (wr_en),
        .mode   (wr_mode),
        .sel    (wr_data[NUM_SRC-1:0]),
        .mask_d (mask_d),
        .mask_q (mask_q)
    );

    irq_summary #(.NUM_SRC(NUM_SRC)) u_sum (
        .clk      (clk),
        .rst      (rst),
        .flags_q  (flags_q),
        .mask_q   (mask_q),
        .flags_d  (flags_d),
        .mask_d   (mask_d),
        .pend_now (pend_now),
        .irq_q    (irq)
    );

    // Read data assembly: flags low, summary on top, gap bits zero.
    assign rd_data[NUM_SRC-1:0] = flags_q;
    assign rd_data[SUM_BIT]     = pend_now;

    if (GAP_W > 0) begin : g_gap
        logic gap_wr_unused;
        assign rd_data[SUM_BIT-1:NUM_SRC] = '0;
        assign gap_wr_unused = ^wr_data[SUM_BIT-1:NUM_SRC];
    end

endmodule

// File: rtl/irq_ctl_checker.sv
module irq_ctl_checker #(
    parameter int NUM_SRC = 5,
    parameter int DATA_W  = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               rd_en,
    input logic               wr_en,
    input logic [DATA_W-1:0]  wr_data,
    input logic [DATA_W-1:0]  rd_data,
    input logic [NUM_SRC-1:0] src_evt,
    input logic               irq,
    input logic [NUM_SRC-1:0] flags_q,
    input logic [NUM_SRC-1:0] mask_q
);

    localparam int SUM_BIT = DATA_W - 1;
    localparam logic [DATA_W-1:0] GAP_MASK =
        ~({DATA_W{1'b0}} | {1'b1, {(DATA_W-1){1'b0}}}) & ~DATA_W'((1 << NUM_SRC) - 1);

    // R1 and R8: every pulsed source shows up as a flag the next cycle.
    p_evt_latched_r1: assert property (@(posedge clk) disable iff (rst)
        (src_evt != '0) |=> ((rd_data[NUM_SRC-1:0] & $past(src_evt)) == $past(src_evt)));

    // R1: gap bits of the read data are zero.
    p_gap_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (rd_data & GAP_MASK) == '0);

    // R3: read summary and the registered request agree.
    p_summary_match_r3: assert property (@(posedge clk) disable iff (rst)
        rd_data[SUM_BIT] == irq);

    // R4: a read with no new event leaves no flag.
    p_read_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && src_evt == '0) |=> (rd_data[NUM_SRC-1:0] == '0));

    // R5: set-mode write turns on the selected mask bits.
    p_mask_set_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[SUM_BIT]) |=>
        ((mask_q & $past(wr_data[NUM_SRC-1:0])) == $past(wr_data[NUM_SRC-1:0])));

    // R6: clear-mode write turns off the selected mask bits.
    p_mask_clr_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[SUM_BIT]) |=> ((mask_q & $past(wr_data[NUM_SRC-1:0])) == '0));

    // R7: the request never stands without an enabled pending flag.
    p_no_masked_irq_r7: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((flags_q & mask_q) != '0));

    // R8: with no read and no clear-mode write, the request holds.
    p_irq_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (irq && !rd_en && !(wr_en && !wr_data[SUM_BIT])) |=> irq);

    // R9: leaving reset, all state is clear.
    p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!irq && flags_q == '0 && mask_q == '0));

endmodule

bind irq_ctl_top irq_ctl_checker #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .src_evt (src_evt),
    .irq     (irq),
    .flags_q (flags_q),
    .mask_q  (mask_q)
);

// File: tb/irq_ctl_top_bench.sv
module irq_ctl_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_SRC    = 5;
    localparam int DATA_W     = 8;
    localparam int N_VEC      = 29;

    // Vector: rd, wr, wdata[8], src[5], chk_rd, exp_rd[8], exp_irq, req[4]
    localparam logic [28:0] VEC [N_VEC] = '{
        {1'b1, 1'b0, 8'h00, 5'h00, 1'b1, 8'h00, 1'b0, 4'd9}, // R9 reset state
        {1'b0, 1'b0, 8'h00, 5'h01, 1'b0, 8'h00, 1'b0, 4'd7}, // R7 masked source
        {1'b1, 1'b0, 8'h00, 5'h00, 1'b1, 8'h01, 1'b0, 4'd2}, // R2 unmasked visible
        {1'b1, 1'b0, 8'h00, 5'h00, 1'b1, 8'h00, 1'b0, 4'd4}, // R4 second read
        {1'b0, 1'b1, 8'h81, 5'h00, 1'b0, 8'h00, 1'b0, 4'd5}, // R5 enable timer A
        {1'b0, 1'b0, 8'h00, 5'h01, 1'b0, 8'h00, 1'b1, 4'd7}, // R7 enabled fires
        {1'b0, 1'b0, 8'h00, 5'h00, 1'b0, 8'h00, 1'b1, 4'd8}, // R8 hold
        {1'b0, 1'b0, 8'h00, 5'h02, 1'b0, 8'h00, 1'b1, 4'd8}, // R8 hold, B pending
        {1'b1, 1'b0, 8'h00, 5'h00, 1'b1, 8'h83, 1'b0, 4'd3}, // R3 summary
        {1'b1, 1'b0, 8'h00, 5'h00, 1'b1, 8'h00, 1'b0, 4'd4}, // R4
        {1'b0, 1'b1, 8'h9E, 5'h00, 1'b0, 8'h00, 1'b0, 4'd5}, // R5 enable rest
        {1'b0, 1'b0, 8'h00, 5'h10, 1'b0, 8'h00, 1'b1, 4'd1}, // R1 ext pin bit4
        {1'b1, 1'b0, 8'h00, 5'h04, 1'b1, 8'h90, 1'b1, 4'd8}, // R8 event during read
        {1'b1, 1'b0, 8'h00, 5'h00, 1'b1, 8'h84, 1'b0, 4'd8}, // R8 kept alarm
        {1'b0, 1'b1, 8'h01, 5'h00, 1'b0, 8'h00, 1'b0, 4'd6}, // R6 clear A
        {1'b0, 1'b0, 8'h00, 5'h01, 1'b0, 8'h00, 1'b0, 4'd6}, // R6 A now masked
        {1'b1, 1'b0, 8'h00, 5'h00, 1'b1, 8'h01, 1'b0, 4'd6}, // R6
        {1'b0, 1'b1, 8'h00, 5'h08, 1'b0, 8'h00, 1'b1, 4'd6}, // R6 zeros keep mask
        {1'b1, 1'b0, 8'h00, 5'h00, 1'b1, 8'h88, 1'b0, 4'd1}, // R1 shift bit3
        {1'b0, 1'b1, 8'h7E, 5'h00, 1'b0, 8'h00, 1'b0, 4'd6}, // R6 clear, gap ignored
        {1'b0, 1'b0, 8'h00, 5'h1F, 1'b0, 8'h00, 1'b0, 4'd7}, // R7 all masked
        {1'b1, 1'b0, 8'h00, 5'h00, 1'b1, 8'h1F, 1'b0, 4'd1}, // R1 all bits, gap 0
        {1'b0, 1'b0, 8'h00, 5'h02, 1'b0, 8'h00, 1'b0, 4'd7}, // R7 B masked
        {1'b0, 1'b1, 8'h82, 5'h00, 1'b0, 8'h00, 1'b1, 4'd7}, // R7 enable pending
        {1'b1, 1'b0, 8'h00, 5'h00, 1'b1, 8'h82, 1'b0, 4'd3}, // R3
        {1'b0, 1'b0, 8'h00, 5'h04, 1'b0, 8'h00, 1'b0, 4'd7}, // R7 alarm masked
        {1'b1, 1'b1, 8'h84, 5'h00, 1'b1, 8'h04, 1'b0, 4'd4}, // R4 read+write
        {1'b0, 1'b0, 8'h00, 5'h04, 1'b0, 8'h00, 1'b1, 4'd5}, // R5 alarm enabled
        {1'b1, 1'b0, 8'h00, 5'h00, 1'b1, 8'h84, 1'b0, 4'd3}  // R3
    };

    logic               clk;
    logic               rst;
    logic               rd_en;
    logic               wr_en;
    logic [DATA_W-1:0]  wr_data;
    logic [DATA_W-1:0]  rd_data;
    logic [NUM_SRC-1:0] src_evt;
    logic               irq;

    int checks;
    int errors;
    bit done;

    irq_ctl_top #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_irq_ctl_top (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .src_evt (src_evt),
        .irq     (irq)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s rd_data actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s irq actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic drive(input logic r, input logic w, input logic [7:0] d,
                         input logic [4:0] s);
        rd_en   = r;
        wr_en   = w;
        wr_data = d;
        src_evt = s;
    endtask

    initial begin
        checks = 0;
        errors = 0;
        done   = 1'b0;
        rst    = 1'b1;
        drive(1'b0, 1'b0, 8'h00, 5'h00);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk1("R9", irq, 1'b0);

        for (int i = 0; i < N_VEC; i++) begin
            drive(VEC[i][28], VEC[i][27], VEC[i][26:19], VEC[i][18:14]);
            #1;
            if (VEC[i][13]) begin
                chk8($sformatf("R%0d vec%0d", VEC[i][3:0], i), rd_data, VEC[i][12:5]);
            end
            @(negedge clk);
            chk1($sformatf("R%0d vec%0d", VEC[i][3:0], i), irq, VEC[i][4]);
        end

        // R9: reset in the middle of activity clears flags and mask.
        drive(1'b0, 1'b1, 8'h81, 5'h01);
        @(negedge clk);
        chk1("R7 pre-reset", irq, 1'b1);
        drive(1'b0, 1'b0, 8'h00, 5'h00);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk1("R9 irq after reset", irq, 1'b0);
        #1;
        chk8("R9 flags after reset", rd_data, 8'h00);
        drive(1'b0, 1'b0, 8'h00, 5'h01);
        @(negedge clk);
        chk1("R9 mask cleared", irq, 1'b0);
        drive(1'b1, 1'b0, 8'h00, 5'h00);
        #1;
        chk8("R9 mask cleared read", rd_data, 8'h01);
        @(negedge clk);
        drive(1'b0, 1'b0, 8'h00, 5'h00);
        @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule